// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Port Front-End

This block is the device-side serial port of a sigma-delta converter, written as a synthesizable model. A host drives chip select, serial clock and serial data in, and the block drives one data-out line. That line carries register read data during a read. At all other times it carries an inverted "result ready" flag. All three host inputs are oversampled in the system clock domain through two-flop synchronizers. A serial clock rising edge is acted on by the port logic one cycle after it leaves the synchronizer.

Each access starts with an 8-bit command byte. Its leading zero bit is the start bit, so clock pulses with the data line held high in idle have no effect. The command byte names a register and a direction. The data phase then moves 8, 16 or 24 bits, most significant bit first. A run of 64 consecutive high data bits puts the port back into frame. It also returns every register to its default. The modulator and filter are modelled by a down-counter. This counter issues one conversion strobe per programmed period. The first strobe after a reset, a framing reset or a rate change comes later than the others, by a fixed settling time. The strobe latches a result into the 24-bit data register and raises the ready flag.

The controller has four states. ST_IDLE waits for a start bit. ST_CMD collects the command byte. ST_WR shifts write data in. ST_RD shifts read data out.

The transitions are as follows:
- start: ST_IDLE to ST_CMD, on a rising edge with DIN low.
- to_read: ST_CMD to ST_RD, on the eighth command bit when bit 6 is set.
- to_write: ST_CMD to ST_WR, on the eighth command bit when bit 6 is clear.
- commit: ST_WR to ST_IDLE, on the last data bit.
- drained: ST_RD to ST_IDLE, on the last data bit.
- abort: any state to ST_IDLE, when chip select goes high.
- resync: any state to ST_IDLE, on the 64th consecutive high bit.

Top module: `sdadc_serial_port`

## Requirements
- R1: While the port is in ST_IDLE, a serial clock rising edge with DIN high has no effect. A rising edge with DIN low is the start bit (command bit 7 = 0), and the next 7 rising edges complete the command byte.
- R2: In the command byte, bit 6 set means read and bit 6 clear means write. Bits 5:0 are the address. The map is as follows:
  - status at 0x00: 8 bits, read-only.
  - rate at 0x01: 16 bits, default SETTLE-free period parameter, 1000 in the bench.
  - result at 0x04: 24 bits, read-only, read with command 0x44.
  - channel at 0x07: 16 bits, default 0x0001.
  - any other address: 8 bits, reads as zero.
- R3: Write data is taken MSB first on rising edges and is committed after its last bit. Writes to read-only or unmapped addresses change nothing.
- R4: Read data leaves MSB first. DOUT changes only after a rising edge, so the host samples each bit just before a rising edge (SPI mode 3).
- R5: 64 consecutive rising edges with DIN high, while chip select is low, return the port to ST_IDLE and every register to its default, ready flag clear. 63 such edges do not.
- R6: dout_oe is low (DOUT released) whenever the synchronized chip select is high, including during reset. It falls within two clock edges of chip select rising.
- R7: With chip select low and no read in progress, DOUT equals the inverted ready flag. It falls when a conversion result is latched.
- R8: Status bit 7 is the inverted ready flag, and bits 6:0 read zero. Reading status does not clear the ready flag.
- R9: Completing a read of the result register clears the ready flag, so DOUT is high after its last bit.
- R10: The first conversion strobe comes exactly SETTLE + P clock edges after reset release, a framing reset or a rate write. After that, a strobe comes every P edges, where P is the rate value (0 acts as 1). Conversions run regardless of chip select.
- R11: The result latched by a conversion is {channel[7:0], n}. Here n is a 16-bit count of conversions since reset, and the first conversion gives n = 1.
- R12: Chip select rising in the middle of a transaction returns the port to ST_IDLE, and the partial write is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Read data, or the inverted ready flag |
| dout_oe | output | 1 | Output enable for dout; low means high impedance |

## Verification
A serial clock rising edge reaches the port logic on the third clock edge after the pin changes: two synchronizer flops, then the edge detector. The bench therefore holds every serial clock level for four clock cycles, and it samples DOUT on the falling clock edge just before it raises the serial clock. Ready timing is counted from reset release in clock edges, on a free-running bench counter. The first ready is expected at edge SETTLE + P and the next at edge SETTLE + 2P, and each is observed on the falling edge that follows. The output enable is checked four cycles after chip select rises, after its two-edge synchronizer has settled.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
    localparam int DATA_W = 24;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR,
        ST_RD
    } sdp_state_e;

    localparam logic [5:0] ADDR_STATUS = 6'h00;
    localparam logic [5:0] ADDR_RATE   = 6'h01;
    localparam logic [5:0] ADDR_RESULT = 6'h04;
    localparam logic [5:0] ADDR_CHAN   = 6'h07;

    // data-phase length for an address
    function automatic logic [4:0] reg_bits(input logic [5:0] a);
        case (a)
            ADDR_RATE, ADDR_CHAN: reg_bits = 5'd16;
            ADDR_RESULT:          reg_bits = 5'd24;
            default:              reg_bits = 5'd8;
        endcase
    endfunction
endpackage

// File: rtl/sdp_sync.sv
module sdp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sdp_conv.sv
module sdp_conv #(
    parameter int          SETTLE_CYC = 68,
    parameter logic [15:0] RATE_RST   = 16'd300
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        restart,
    input  logic [15:0] rate,
    output logic        done
);
    localparam int CW = 18;
    localparam logic [CW-1:0] FIRST_RST = CW'(SETTLE_CYC) + CW'(RATE_RST) - 1'b1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] per;

    assign per  = (rate == 16'd0) ? CW'(1) : CW'(rate);
    assign done = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= FIRST_RST;
        else if (soft_rst) cnt <= FIRST_RST;
        else if (restart)  cnt <= CW'(SETTLE_CYC) + per - 1'b1;
        else if (done)     cnt <= per - 1'b1;
        else               cnt <= cnt - 1'b1;
    end

    // settling delay follows every restart
    assert_settle_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst || restart) |=> !done);
endmodule

// File: rtl/sdp_regs.sv
module sdp_regs
    import sdp_pkg::*;
#(
    parameter logic [15:0] RATE_RST = 16'd300,
    parameter logic [15:0] CHAN_RST = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [5:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [5:0]        rd_addr,
    input  logic              rd_clr,
    input  logic              conv_done,
    output logic [DATA_W-1:0] rd_word,
    output logic              rdy_n,
    output logic [15:0]       rate,
    output logic              restart
);
    logic [15:0]       rate_q;
    logic [15:0]       chan_q;
    logic [15:0]       count_q;
    logic [DATA_W-1:0] result_q;
    logic              rdy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q   <= RATE_RST;
            chan_q   <= CHAN_RST;
            count_q  <= '0;
            result_q <= '0;
            rdy_q    <= 1'b0;
            restart  <= 1'b0;
        end else if (soft_rst) begin
            rate_q   <= RATE_RST;
            chan_q   <= CHAN_RST;
            count_q  <= '0;
            result_q <= '0;
            rdy_q    <= 1'b0;
            restart  <= 1'b0;
        end else begin
            restart <= wr_en && (wr_addr == ADDR_RATE);
            if (wr_en) begin
                case (wr_addr)
                    ADDR_RATE: rate_q <= wr_data[15:0];
                    ADDR_CHAN: chan_q <= wr_data[15:0];
                    default:   ;
                endcase
            end
            if (conv_done) begin
                count_q  <= count_q + 16'd1;
                result_q <= {chan_q[7:0], count_q + 16'd1};
                rdy_q    <= 1'b1;
            end else if (rd_clr) begin
                rdy_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_STATUS: rd_word = {16'h0, ~rdy_q, 7'h0};
            ADDR_RATE:   rd_word = {8'h0, rate_q};
            ADDR_RESULT: rd_word = result_q;
            ADDR_CHAN:   rd_word = {8'h0, chan_q};
            default:     rd_word = '0;
        endcase
    end

    assign rdy_n = ~rdy_q;
    assign rate  = rate_q;

    assert_ready_on_conv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !soft_rst) |=> !rdy_n);
    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !conv_done && !soft_rst) |=> rdy_n);
    assert_resync_defaults_R5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (rate_q == RATE_RST && chan_q == CHAN_RST && rdy_n));
    assert_rate_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_RATE && !soft_rst) |=> rate_q == $past(wr_data[15:0]));
endmodule

// File: rtl/sdp_ctrl.sv
module sdp_ctrl
    import sdp_pkg::*;
#(
    parameter int RESYNC_ONES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              rdy_n,
    output logic [5:0]        rd_addr,
    output logic [5:0]        wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_en,
    output logic              rd_clr,
    output logic              soft_rst,
    output logic              dout,
    output logic              dout_oe
);
    localparam int OW = $clog2(RESYNC_ONES);

    sdp_state_e        state, state_nxt;
    logic              sclk_d;
    logic              active;
    logic [4:0]        bit_cnt;
    logic [4:0]        width_q;
    logic [6:0]        cmd_sh;
    logic [7:0]        cmd_nxt;
    logic [5:0]        addr_q;
    logic [DATA_W-1:0] sh;
    logic [OW-1:0]     ones_cnt;

    assign active   = sclk_s & ~sclk_d & ~cs_s;
    assign cmd_nxt  = {cmd_sh, din_s};
    assign rd_addr  = cmd_nxt[5:0];
    assign wr_addr  = addr_q;
    assign wr_data  = {sh[DATA_W-2:0], din_s};
    assign soft_rst = active & din_s & (ones_cnt == OW'(RESYNC_ONES - 1));

    // next state and strobes
    always_comb begin
        state_nxt = state;
        wr_en     = 1'b0;
        rd_clr    = 1'b0;
        if (cs_s || soft_rst) begin
            state_nxt = ST_IDLE;
        end else if (active) begin
            unique case (state)
                ST_IDLE: if (!din_s) state_nxt = ST_CMD;
                ST_CMD:  if (bit_cnt == 5'd7) state_nxt = cmd_nxt[6] ? ST_RD : ST_WR;
                ST_WR: begin
                    if (bit_cnt == width_q - 5'd1) begin
                        wr_en     = 1'b1;
                        state_nxt = ST_IDLE;
                    end
                end
                ST_RD: begin
                    if (bit_cnt == width_q - 5'd1) begin
                        rd_clr    = (addr_q == ADDR_RESULT);
                        state_nxt = ST_IDLE;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // shift datapath and framing counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d   <= 1'b1;
            bit_cnt  <= '0;
            width_q  <= 5'd8;
            cmd_sh   <= '0;
            addr_q   <= '0;
            sh       <= '0;
            ones_cnt <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (cs_s || soft_rst)  ones_cnt <= '0;
            else if (active)       ones_cnt <= din_s ? ones_cnt + 1'b1 : '0;

            if (cs_s || soft_rst) begin
                bit_cnt <= '0;
            end else if (active) begin
                unique case (state)
                    ST_IDLE: begin
                        if (!din_s) begin
                            bit_cnt <= 5'd1;
                            cmd_sh  <= {6'h0, din_s};
                        end
                    end
                    ST_CMD: begin
                        if (bit_cnt == 5'd7) begin
                            addr_q  <= cmd_nxt[5:0];
                            width_q <= reg_bits(cmd_nxt[5:0]);
                            bit_cnt <= '0;
                            sh      <= cmd_nxt[6]
                                     ? rd_word << (5'(DATA_W) - reg_bits(cmd_nxt[5:0]))
                                     : '0;
                        end else begin
                            cmd_sh  <= cmd_nxt[6:0];
                            bit_cnt <= bit_cnt + 5'd1;
                        end
                    end
                    ST_WR: begin
                        sh      <= {sh[DATA_W-2:0], din_s};
                        bit_cnt <= bit_cnt + 5'd1;
                    end
                    ST_RD: begin
                        sh      <= {sh[DATA_W-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 5'd1;
                    end
                endcase
            end
        end
    end

    assign dout    = (state == ST_RD) ? sh[DATA_W-1] : rdy_n;
    assign dout_oe = ~cs_s;

    assert_cs_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> state == ST_IDLE);
    assert_idle_filter_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && active && din_s && !soft_rst) |=> state == ST_IDLE);
    assert_no_write_deselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |-> !wr_en && !rd_clr);
endmodule

// File: rtl/sdadc_serial_port.sv
module sdadc_serial_port
    import sdp_pkg::*;
#(
    parameter int          SETTLE_CYC  = 68,
    parameter logic [15:0] RATE_RST    = 16'd300,
    parameter logic [15:0] CHAN_RST    = 16'h0001,
    parameter int          RESYNC_ONES = 64,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic din,
    output logic dout,
    output logic dout_oe
);
    localparam int NPIN = 3;

    logic [NPIN-1:0]   pin_raw;
    logic [NPIN-1:0]   pin_s;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] wr_data;
    logic [5:0]        rd_addr;
    logic [5:0]        wr_addr;
    logic              wr_en;
    logic              rd_clr;
    logic              soft_rst;
    logic              rdy_n;
    logic [15:0]       rate;
    logic              restart;
    logic              conv_done;

    assign pin_raw = {cs_n, sclk, din};

    for (genvar g = 0; g < NPIN; g++) begin : g_sync
        sdp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pin_raw[g]),
            .q     (pin_s[g])
        );
    end

    sdp_ctrl #(.RESYNC_ONES(RESYNC_ONES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s     (pin_s[2]),
        .sclk_s   (pin_s[1]),
        .din_s    (pin_s[0]),
        .rd_word  (rd_word),
        .rdy_n    (rdy_n),
        .rd_addr  (rd_addr),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_en    (wr_en),
        .rd_clr   (rd_clr),
        .soft_rst (soft_rst),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    sdp_regs #(.RATE_RST(RATE_RST), .CHAN_RST(CHAN_RST)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_clr    (rd_clr),
        .conv_done (conv_done),
        .rd_word   (rd_word),
        .rdy_n     (rdy_n),
        .rate      (rate),
        .restart   (restart)
    );

    sdp_conv #(.SETTLE_CYC(SETTLE_CYC), .RATE_RST(RATE_RST)) u_conv (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .restart  (restart),
        .rate     (rate),
        .done     (conv_done)
    );
endmodule

// File: tb/sdadc_serial_port_tb_top.sv
module sdadc_serial_port_tb_top;
    localparam int          SETTLE = 68;
    localparam int          PER    = 1000;
    localparam logic [15:0] CHDEF  = 16'h0001;
    localparam int          HALF   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b1;
    logic din = 1'b1;
    logic dout, dout_oe;
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    sdadc_serial_port #(
        .SETTLE_CYC (SETTLE),
        .RATE_RST   (16'(PER)),
        .CHAN_RST   (CHDEF)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .din     (din),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    function automatic int bits_of(input logic [5:0] a);
        if (a == 6'h01 || a == 6'h07) return 16;
        if (a == 6'h04) return 24;
        return 8;
    endfunction

    function automatic logic [23:0] result_of(input logic [15:0] ch, input int n);
        return {ch[7:0], 16'(n)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b, output logic o);
        @(negedge clk);
        sclk = 1'b0;
        din  = b;
        wait_clk(HALF);
        o    = dout;
        sclk = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic select();
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(3);
    endtask

    task automatic deselect();
        @(negedge clk);
        cs_n = 1'b1;
        din  = 1'b1;
        wait_clk(4);
    endtask

    task automatic xfer(input logic [7:0] cmd, input logic [23:0] wd, output logic [23:0] rd);
        logic o;
        int   nb;
        nb = bits_of(cmd[5:0]);
        if (cs_n) select();
        for (int i = 7; i >= 0; i--) sbit(cmd[i], o);
        rd = '0;
        for (int i = nb - 1; i >= 0; i--) begin
            sbit(cmd[6] ? 1'b1 : wd[i], o);
            rd = {rd[22:0], o};
        end
        din = 1'b1;
    endtask

    task automatic wait_ready();
        while (!(dout_oe === 1'b1 && dout === 1'b0)) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] rd;
        logic        o;
        logic [15:0] m_rate, m_chan;
        void'($urandom(32'd1234));
        m_rate = 16'(PER);
        m_chan = CHDEF;

        cs_n = 1'b0;
        wait_clk(5);
        check("R6 reset releases dout", 32'(dout_oe), 32'd0);
        rst_n = 1'b1;

        // R10 first conversion after settle
        wait_ready();
        check("R10 first ready edge", 32'(cyc), 32'(SETTLE + PER));
        xfer(8'h40, 24'h0, rd);
        check("R8 status when ready", 32'(rd[7:0]), 32'h00);
        xfer(8'h40, 24'h0, rd);
        check("R8 status read keeps ready", 32'(rd[7:0]), 32'h00);
        xfer(8'h44, 24'h0, rd);
        check("R11 R4 first result", 32'(rd), 32'(result_of(m_chan, 1)));
        wait_clk(2);
        check("R9 dout high after result read", 32'(dout), 32'd1);
        xfer(8'h40, 24'h0, rd);
        check("R8 status not ready", 32'(rd[7:0]), 32'h80);

        wait_ready();
        check("R10 period to second ready", 32'(cyc), 32'(SETTLE + 2 * PER));
        check("R7 dout low on ready", 32'(dout), 32'd0);
        xfer(8'h44, 24'h0, rd);
        check("R11 second result", 32'(rd), 32'(result_of(m_chan, 2)));

        deselect();
        check("R6 released while deselected", 32'(dout_oe), 32'd0);
        while (cyc < SETTLE + 3 * PER + 20) @(negedge clk);
        select();
        check("R10 conversion ran while deselected", 32'({dout_oe, dout}), 32'b10);
        xfer(8'h44, 24'h0, rd);
        check("R11 third result", 32'(rd), 32'(result_of(m_chan, 3)));

        xfer(8'h41, 24'h0, rd);
        check("R2 rate default", 32'(rd), 32'(m_rate));
        xfer(8'h47, 24'h0, rd);
        check("R2 channel default", 32'(rd), 32'(m_chan));

        // R1 idle pulses with DIN high
        for (int i = 0; i < 5; i++) sbit(1'b1, o);
        xfer(8'h41, 24'h0, rd);
        check("R1 idle ones ignored", 32'(rd), 32'(m_rate));

        xfer(8'h07, 24'h00A53C, rd);
        m_chan = 16'hA53C;
        xfer(8'h47, 24'h0, rd);
        check("R3 channel write", 32'(rd), 32'(m_chan));
        xfer(8'h20, 24'h00005A, rd);
        xfer(8'h60, 24'h0, rd);
        check("R3 R2 unmapped write ignored", 32'(rd), 32'h0);

        // R12 abort mid-write
        deselect();
        select();
        for (int i = 7; i >= 0; i--) sbit(i < 3 ? 1'b1 : 1'b0, o);
        for (int i = 0; i < 6; i++) sbit(1'b0, o);
        deselect();
        check("R12 R6 oe low after abort", 32'(dout_oe), 32'd0);
        xfer(8'h47, 24'h0, rd);
        check("R12 partial write discarded", 32'(rd), 32'(m_chan));

        // random register traffic
        for (int k = 0; k < 24; k++) begin
            int sel;
            logic [15:0] v;
            sel = int'($urandom % 3);
            v   = 16'($urandom);
            if (sel == 0) begin
                xfer(8'h07, {8'h0, v}, rd);
                m_chan = v;
            end else if (sel == 1) begin
                v = 16'(500 + ($urandom % 4000));
                xfer(8'h01, {8'h0, v}, rd);
                m_rate = v;
            end else begin
                logic [5:0] a;
                a = 6'(8 + ($urandom % 48));
                xfer({2'b00, a}, {8'h0, v}, rd);
                xfer({2'b01, a}, 24'h0, rd);
                check("R2 random unmapped reads zero", 32'(rd), 32'h0);
            end
            xfer(8'h47, 24'h0, rd);
            check("R3 random channel", 32'(rd), 32'(m_chan));
            xfer(8'h41, 24'h0, rd);
            check("R3 random rate", 32'(rd), 32'(m_rate));
        end

        // R5 framing reset boundary
        xfer(8'h07, 24'h001234, rd);
        m_chan = 16'h1234;
        deselect();
        select();
        for (int i = 0; i < 63; i++) sbit(1'b1, o);
        xfer(8'h47, 24'h0, rd);
        check("R5 63 ones keep registers", 32'(rd), 32'(m_chan));
        deselect();
        select();
        for (int i = 0; i < 64; i++) sbit(1'b1, o);
        wait_clk(2);
        check("R5 ready cleared by resync", 32'(dout), 32'd1);
        xfer(8'h47, 24'h0, rd);
        check("R5 channel back to default", 32'(rd), 32'(CHDEF));
        xfer(8'h41, 24'h0, rd);
        check("R5 rate back to default", 32'(rd), 32'(PER));
        deselect();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule